// File: doc/BRIEF.md
# Write-Only Two-Wire Converter Command Receiver

This block is the receive side of a two-wire (I2C) target that feeds a single-channel digital-to-analog converter. It samples the bus clock and data lines on the system clock and finds START and STOP conditions. It checks the 7-bit target address and the direction bit, and it acknowledges by raising an active-high pull-down enable for the external open-drain SDA driver. After a matched write address, it gathers three data bytes into a 24-bit command word. The word goes to the converter's command logic as a one-cycle strobe.

The target answers two addresses. One comes from strap inputs. The other is a fixed broadcast address that lets one transaction load every converter on the bus. Read requests are never answered. Bytes after the third in the same transaction are refused. A busy flag shows when a word is partly received, so surrounding logic can hold off an update that would otherwise use a half-loaded word.

Top module: `dac_i2c_target`

## Requirements
- R1: After reset, `sda_pull_o`, `busy_o` and `word_valid_o` are low. A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. Both lines idle high.
- R2: Bits are taken on SCL rising edges, most significant bit first: seven address bits, then the direction bit (0 = write). A write to the strap address `dev_addr_i` is acknowledged by `sda_pull_o` being high while SCL is high on the 9th clock.
- R3: A write to the broadcast address (parameter `BCAST_ADDR`) is acknowledged and loads a word in the same way.
- R4: An address that matches neither address gets no acknowledge. No data byte after it is acknowledged, and no word is produced.
- R5: A read request (direction bit 1) to a matching address is never acknowledged. SDA stays released through the 9th clock, and no word is produced.
- R6: Each of the first three data bytes after a matched write address is acknowledged. `word_valid_o` pulses for one cycle after the falling SCL edge of the 9th clock of the third byte. `word_o` then equals {byte1, byte2, byte3}, with byte1 in bits 23:16.
- R7: Data bytes after the third in one transaction are not acknowledged, and no further strobe is produced.
- R8: An acknowledge pull-down is released on the SCL falling edge that ends the acknowledge clock.
- R9: `busy_o` rises with the first data bit of a word. It is high between data bytes and low after the word completes. It is low during the address phase.
- R10: A repeated START in the middle of a word drops the partial word, clears `busy_o` and restarts the address phase. A following complete write delivers only its own three bytes.
- R11: A STOP in the middle of a word clears `busy_o` and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| dev_addr_i | input | 7 | Strap-selected target address |
| sda_pull_o | output | 1 | High to pull SDA low (acknowledge) |
| word_valid_o | output | 1 | One-cycle strobe for a completed 24-bit word |
| word_o | output | 24 | Last completed word, first byte in the upper bits |
| busy_o | output | 1 | A word is partly received |

## Verification
The bench checks the acknowledge decision in every case that should differ: the strap address, the broadcast address, a near-miss address and a read request. A target that decoded the direction bit wrongly would acknowledge reads, and a loose compare would answer a neighbouring address. It sends five bytes to catch a target that keeps acknowledging or strobes a second word. It aborts words with a repeated START and with a STOP; a design that kept its byte count would then deliver a word mixing old and new bytes. The acknowledge is also checked for release after the 9th clock, because a late release would corrupt the first bit of the next byte.

// File: rtl/dac_i2c_pkg.sv
package dac_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  // 9 SCL clocks per byte: 8 data bits plus the acknowledge clock
  localparam int BIT_CNT_W = 4;
  localparam logic [BIT_CNT_W-1:0] LAST_DATA_BIT = 4'd8;
  localparam logic [BIT_CNT_W-1:0] ACK_CLOCK = 4'd9;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_ADDR = 2'd1,
    RX_DATA = 2'd2,
    RX_SKIP = 2'd3
  } rx_state_t;
endpackage

// File: rtl/bus_line_sync.sv
// Synchronizes SCL and SDA and derives clock edges plus START/STOP events.
module bus_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_lvl_o
);
  localparam int LINES = 2;
  localparam int SCL_IDX = 0;
  localparam int SDA_IDX = 1;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] cur;
  logic [LINES-1:0] prev;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '1;
      end else begin
        chain <= {chain[STAGES-2:0], raw[g]};
      end
    end
    assign cur[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= cur;
  end

  assign scl_rise_o = cur[SCL_IDX] & ~prev[SCL_IDX];
  assign scl_fall_o = ~cur[SCL_IDX] & prev[SCL_IDX];
  assign start_o    = cur[SCL_IDX] & prev[SCL_IDX] & prev[SDA_IDX] & ~cur[SDA_IDX];
  assign stop_o     = cur[SCL_IDX] & prev[SCL_IDX] & ~prev[SDA_IDX] & cur[SDA_IDX];
  assign sda_lvl_o  = cur[SDA_IDX];
endmodule

// File: rtl/addr_match.sv
// Decides whether an address byte is a write to this target.
module addr_match #(
  parameter logic [6:0] BCAST_ADDR = 7'h73
) (
  input  logic [7:0] addr_byte_i,
  input  logic [6:0] dev_addr_i,
  output logic       hit_o
);
  logic [6:0] addr;
  logic       is_read;

  assign addr    = addr_byte_i[7:1];
  assign is_read = addr_byte_i[0];
  assign hit_o   = ~is_read & ((addr == dev_addr_i) | (addr == BCAST_ADDR));
endmodule

// File: rtl/word_rx_engine.sv
// Byte framing, acknowledge control and 24-bit word assembly.
module word_rx_engine
  import dac_i2c_pkg::*;
#(
  parameter int         DATA_BYTES = 3,
  parameter logic [6:0] BCAST_ADDR = 7'h73
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       scl_rise_i,
  input  logic                       scl_fall_i,
  input  logic                       start_i,
  input  logic                       stop_i,
  input  logic                       sda_lvl_i,
  input  logic [ADDR_W-1:0]          dev_addr_i,
  output logic                       pull_o,
  output logic                       valid_o,
  output logic [DATA_BYTES*BYTE_W-1:0] word_o,
  output logic                       busy_o
);
  localparam int WORD_W = DATA_BYTES * BYTE_W;
  localparam int IDX_W  = $clog2(DATA_BYTES + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BYTES - 1);
  localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(DATA_BYTES);

  rx_state_t            state;
  logic [BIT_CNT_W-1:0] bit_cnt;
  logic [BYTE_W-1:0]    shreg;
  logic [IDX_W-1:0]     byte_idx;
  logic [WORD_W-1:0]    acc;
  logic                 addr_hit;
  logic                 room;

  addr_match #(.BCAST_ADDR(BCAST_ADDR)) u_match (
    .addr_byte_i (shreg),
    .dev_addr_i  (dev_addr_i),
    .hit_o       (addr_hit)
  );

  assign room = (byte_idx < IDX_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_idx <= '0;
      acc      <= '0;
      word_o   <= '0;
      pull_o   <= 1'b0;
      valid_o  <= 1'b0;
      busy_o   <= 1'b0;
    end else if (start_i) begin
      state    <= RX_ADDR;
      bit_cnt  <= '0;
      byte_idx <= '0;
      pull_o   <= 1'b0;
      valid_o  <= 1'b0;
      busy_o   <= 1'b0;
    end else if (stop_i) begin
      state    <= RX_IDLE;
      bit_cnt  <= '0;
      pull_o   <= 1'b0;
      valid_o  <= 1'b0;
      busy_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (scl_rise_i && state != RX_IDLE) begin
        if (bit_cnt < LAST_DATA_BIT) shreg <= {shreg[BYTE_W-2:0], sda_lvl_i};
        bit_cnt <= bit_cnt + 1'b1;
        if (state == RX_DATA && bit_cnt == '0 && byte_idx == '0) busy_o <= 1'b1;
      end
      if (scl_fall_i && state != RX_IDLE) begin
        if (bit_cnt == LAST_DATA_BIT) begin
          if (state == RX_ADDR) begin
            pull_o <= addr_hit;
          end else if (state == RX_DATA && room) begin
            pull_o <= 1'b1;
            acc    <= {acc[WORD_W-BYTE_W-1:0], shreg};
          end
        end else if (bit_cnt == ACK_CLOCK) begin
          pull_o  <= 1'b0;
          bit_cnt <= '0;
          if (state == RX_ADDR) begin
            state <= pull_o ? RX_DATA : RX_SKIP;
          end else if (state == RX_DATA && room) begin
            byte_idx <= byte_idx + 1'b1;
            if (byte_idx == IDX_LAST) begin
              valid_o <= 1'b1;
              word_o  <= acc;
              busy_o  <= 1'b0;
            end
          end
        end
      end
    end
  end

  // R8
  pull_rise_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pull_o) |-> $past(scl_fall_i));
  // R8
  pull_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pull_o) |-> $past(scl_fall_i || start_i || stop_i));
  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(scl_rise_i));
  // R10
  start_clears_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !busy_o && !pull_o);
endmodule

// File: rtl/dac_i2c_target.sv
module dac_i2c_target #(
  parameter int         SYNC_STAGES = 2,
  parameter int         DATA_BYTES  = 3,
  parameter logic [6:0] BCAST_ADDR  = 7'h73
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [6:0]            dev_addr_i,
  output logic                  sda_pull_o,
  output logic                  word_valid_o,
  output logic [DATA_BYTES*8-1:0] word_o,
  output logic                  busy_o
);
  logic scl_rise, scl_fall, start_evt, stop_evt, sda_lvl;

  bus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt),
    .sda_lvl_o  (sda_lvl)
  );

  word_rx_engine #(.DATA_BYTES(DATA_BYTES), .BCAST_ADDR(BCAST_ADDR)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_evt),
    .stop_i     (stop_evt),
    .sda_lvl_i  (sda_lvl),
    .dev_addr_i (dev_addr_i),
    .pull_o     (sda_pull_o),
    .valid_o    (word_valid_o),
    .word_o     (word_o),
    .busy_o     (busy_o)
  );

  // R9
  valid_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |-> !busy_o);
  // R11
  stop_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !word_valid_o && !busy_o);
endmodule

// File: tb/dac_i2c_target_test.sv
module dac_i2c_target_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam int H = 12;
  localparam logic [6:0] OWN = 7'h10;
  localparam logic [6:0] BC  = 7'h73;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus;
  logic sda_pull_o, word_valid_o, busy_o;
  logic [23:0] word_o;

  int checks = 0;
  int fails = 0;
  int vcount = 0;
  logic [23:0] last_word = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull_o;

  dac_i2c_target #(.BCAST_ADDR(BC)) uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
    .dev_addr_i(OWN), .sda_pull_o(sda_pull_o), .word_valid_o(word_valid_o),
    .word_o(word_o), .busy_o(busy_o)
  );

  always @(negedge clk) if (!rst && word_valid_o) begin
    vcount++;
    last_word = word_o;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    bit ack;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(Q);
      scl_m = 1'b1; wt(H);
      scl_m = 1'b0; wt(Q);
    end
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(H/2);
    ack = ~sda_bus;
    wt(H - H/2);
    scl_m = 1'b0; wt(Q);
    chk(ack == exp_ack, req, {31'd0, ack}, {31'd0, exp_ack});
    if (exp_ack) chk(sda_pull_o == 1'b0, "R8", {31'd0, sda_pull_o}, 32'd0);
  endtask

  task automatic t_reset();
    chk(sda_pull_o == 0 && busy_o == 0 && word_valid_o == 0, "R1",
        {29'd0, sda_pull_o, busy_o, word_valid_o}, 32'd0);
  endtask

  task automatic t_own_write();
    int v0 = vcount;
    bus_start();
    send_byte({OWN, 1'b0}, 1'b1, "R2");
    chk(busy_o == 0, "R9", {31'd0, busy_o}, 32'd0);
    send_byte(8'hA5, 1'b1, "R6");
    chk(busy_o == 1, "R9", {31'd0, busy_o}, 32'd1);
    send_byte(8'h3C, 1'b1, "R6");
    send_byte(8'h81, 1'b1, "R6");
    chk(busy_o == 0, "R9", {31'd0, busy_o}, 32'd0);
    bus_stop();
    chk(vcount == v0 + 1, "R6", vcount, v0 + 1);
    chk(last_word == 24'hA53C81, "R6", {8'd0, last_word}, 32'hA53C81);
  endtask

  task automatic t_bcast();
    int v0 = vcount;
    bus_start();
    send_byte({BC, 1'b0}, 1'b1, "R3");
    send_byte(8'h10, 1'b1, "R3");
    send_byte(8'h20, 1'b1, "R3");
    send_byte(8'h30, 1'b1, "R3");
    bus_stop();
    chk(vcount == v0 + 1 && last_word == 24'h102030, "R3", {8'd0, last_word}, 32'h102030);
  endtask

  task automatic t_mismatch();
    int v0 = vcount;
    bus_start();
    send_byte({OWN ^ 7'h01, 1'b0}, 1'b0, "R4");
    for (int i = 0; i < 3; i++) send_byte(8'h55, 1'b0, "R4");
    chk(busy_o == 0, "R4", {31'd0, busy_o}, 32'd0);
    bus_stop();
    chk(vcount == v0, "R4", vcount, v0);
  endtask

  task automatic t_read();
    int v0 = vcount;
    bus_start();
    send_byte({OWN, 1'b1}, 1'b0, "R5");
    for (int i = 0; i < 3; i++) send_byte(8'hC3, 1'b0, "R5");
    bus_stop();
    chk(vcount == v0, "R5", vcount, v0);
  endtask

  task automatic t_extra();
    int v0 = vcount;
    bus_start();
    send_byte({OWN, 1'b0}, 1'b1, "R7");
    send_byte(8'h01, 1'b1, "R7");
    send_byte(8'h02, 1'b1, "R7");
    send_byte(8'h03, 1'b1, "R7");
    send_byte(8'hEE, 1'b0, "R7");
    send_byte(8'hDD, 1'b0, "R7");
    chk(busy_o == 0, "R7", {31'd0, busy_o}, 32'd0);
    bus_stop();
    chk(vcount == v0 + 1 && last_word == 24'h010203, "R7", {8'd0, last_word}, 32'h010203);
  endtask

  task automatic t_restart();
    int v0 = vcount;
    bus_start();
    send_byte({OWN, 1'b0}, 1'b1, "R10");
    send_byte(8'h99, 1'b1, "R10");
    send_byte(8'h88, 1'b1, "R10");
    bus_start();
    chk(busy_o == 0, "R10", {31'd0, busy_o}, 32'd0);
    send_byte({OWN, 1'b0}, 1'b1, "R10");
    send_byte(8'h44, 1'b1, "R10");
    send_byte(8'h55, 1'b1, "R10");
    send_byte(8'h66, 1'b1, "R10");
    bus_stop();
    chk(vcount == v0 + 1 && last_word == 24'h445566, "R10", {8'd0, last_word}, 32'h445566);
  endtask

  task automatic t_stop_abort();
    int v0 = vcount;
    bus_start();
    send_byte({BC, 1'b0}, 1'b1, "R11");
    send_byte(8'h7E, 1'b1, "R11");
    chk(busy_o == 1, "R11", {31'd0, busy_o}, 32'd1);
    bus_stop();
    chk(busy_o == 0 && vcount == v0, "R11 R1", {31'd0, busy_o}, 32'd0);
    bus_start();
    send_byte({OWN, 1'b0}, 1'b1, "R11");
    send_byte(8'hF0, 1'b1, "R11");
    send_byte(8'h0F, 1'b1, "R11");
    send_byte(8'h5A, 1'b1, "R11");
    bus_stop();
    chk(vcount == v0 + 1 && last_word == 24'hF00F5A, "R11", {8'd0, last_word}, 32'hF00F5A);
  endtask

  initial begin
    wt(5);
    rst = 1'b0;
    wt(5);
    t_reset();
    t_own_write();
    t_bcast();
    t_mismatch();
    t_read();
    t_extra();
    t_restart();
    t_stop_abort();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule